// File: doc/BRIEF.md
# Addressed Packet Receiver with Timeouts

This block takes one framed packet off a shared open-drain data line once the attention line has fallen. It turns the line into UART-style bytes: a low start bit, eight data bits sent least-significant bit first, and a high stop bit. A bounded timeout guards every wait for a start edge and every wait for a stop level. The first byte names the destination node. The second byte gives the length of the payload. After that come the payload bytes and one trailing checksum byte.

Accepted bytes go out through a byte write port to a local buffer. The block checks neither the checksum nor buffer ownership. When a packet ends, the block gives a single-cycle done pulse with a status code:
- packet received,
- not for this node,
- I/O error (a timeout),
- content error (the length is out of range).

Top module: `addr_pkt_receiver`

## Requirements
- R1: A reception starts only on a high-to-low transition of `attn_in` seen while idle; activity on `data_in` without that transition causes neither writes nor a done pulse.
- R2: Once a byte is expected, if `data_in` does not go low within `TIMEOUT_CLKS` clock cycles, the packet ends with status 2 (I/O error).
- R3: Each byte is sampled at mid-bit. The start edge is followed by half of `CLK_PER_BIT`, then by eight samples spaced `CLK_PER_BIT` cycles apart, and the first sample becomes bit 0 of the byte.
- R4: After the eighth data bit, if `data_in` is not high within `TIMEOUT_CLKS` cycles, the packet ends with status 2.
- R5: With filtering on (`ACCEPT_ALL`=0), a first byte equal to `own_addr` or to 0xFF is accepted. Any other first byte ends the packet with status 1 (not for me) and no buffer write.
- R6: With `ACCEPT_ALL`=1, every destination byte is accepted.
- R7: The accepted address is written to buffer index 0 and the length byte to index 1. A length greater than or equal to `MAX_LEN` then ends the packet with status 3 (content error), and no further write follows.
- R8: For a length L below `MAX_LEN`, the next L+1 bytes are written in arrival order to indices 2 through L+2, and the packet then ends with status 0 (received).
- R9: `pkt_done` is high for exactly one cycle per packet and `pkt_status` is valid with it. Status codes: 0 received, 1 not for me, 2 I/O error, 3 content error. After a done pulse no write occurs until the next attention fall.
- R10: After reset, `pkt_done` and `buf_wr_en` are low.
- R11: A timeout after some bytes have been stored ends the packet with status 2, and the bytes already written stay written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | 8 | This node's address |
| data_in | input | 1 | Synchronized serial data line |
| attn_in | input | 1 | Synchronized attention line, active low |
| buf_wr_en | output | 1 | Buffer byte write strobe |
| buf_wr_addr | output | BUF_AW | Buffer byte index |
| buf_wr_data | output | 8 | Byte to store |
| pkt_done | output | 1 | One-cycle end-of-packet pulse |
| pkt_status | output | 2 | Result code, valid with `pkt_done` |

## Verification
The bench builds two instances with `CLK_PER_BIT`=8, `TIMEOUT_CLKS`=40 and `MAX_LEN`=6. One instance has filtering on and the other has `ACCEPT_ALL`=1. Both share the same lines, so each packet exercises both filter variants at once. The short bit time and timeout make each kind of timeout happen within a few dozen cycles. The small length limit means that a length of exactly the limit, and a packet filling the top buffer index, take only a handful of bytes to reach.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

    typedef enum logic [1:0] {
        PKT_OK          = 2'd0,
        PKT_NOT_MINE    = 2'd1,
        PKT_IO_ERR      = 2'd2,
        PKT_CONTENT_ERR = 2'd3
    } pkt_status_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_WAIT_LOW,
        RX_HALF,
        RX_BITS,
        RX_WAIT_HIGH
    } rx_state_e;

    typedef enum logic [1:0] {
        C_IDLE,
        C_ADDR,
        C_LEN,
        C_BODY
    } ctl_state_e;

    localparam logic [7:0] BCAST_ADDR = 8'hFF;

    function automatic logic dest_accepted(input logic [7:0] own,
                                           input logic [7:0] dest,
                                           input bit accept_all);
        return accept_all || (dest == own) || (dest == BCAST_ADDR);
    endfunction

endpackage

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
    import pkt_rx_pkg::*;
#(
    parameter int CLK_PER_BIT  = 434,
    parameter int TIMEOUT_CLKS = 50000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_start,
    input  logic       line_in,
    output logic       byte_valid,
    output logic       byte_err,
    output logic [7:0] byte_data
);
    localparam int HALF_BIT = (CLK_PER_BIT / 2 < 1) ? 1 : CLK_PER_BIT / 2;
    localparam int CW       = $clog2(CLK_PER_BIT + 1);
    localparam int TW       = $clog2(TIMEOUT_CLKS + 1);

    rx_state_e       st;
    logic [CW-1:0]   cnt;
    logic [TW-1:0]   tcnt;
    logic [2:0]      bitn;
    logic [7:0]      shreg;

    assign byte_data = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= RX_IDLE;
            cnt        <= '0;
            tcnt       <= '0;
            bitn       <= '0;
            shreg      <= '0;
            byte_valid <= 1'b0;
            byte_err   <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            byte_err   <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (byte_start) begin
                        st   <= RX_WAIT_LOW;
                        tcnt <= '0;
                    end
                end
                RX_WAIT_LOW: begin
                    if (!line_in) begin
                        st  <= RX_HALF;
                        cnt <= '0;
                    end else if (tcnt == TW'(TIMEOUT_CLKS - 1)) begin
                        byte_err <= 1'b1;
                        st       <= RX_IDLE;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                RX_HALF: begin
                    if (cnt == CW'(HALF_BIT - 1)) begin
                        st   <= RX_BITS;
                        cnt  <= '0;
                        bitn <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_BITS: begin
                    if (cnt == CW'(CLK_PER_BIT - 1)) begin
                        cnt   <= '0;
                        shreg <= {line_in, shreg[7:1]};
                        if (bitn == 3'd7) begin
                            st   <= RX_WAIT_HIGH;
                            tcnt <= '0;
                        end else begin
                            bitn <= bitn + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_WAIT_HIGH: begin
                    if (line_in) begin
                        byte_valid <= 1'b1;
                        st         <= RX_IDLE;
                    end else if (tcnt == TW'(TIMEOUT_CLKS - 1)) begin
                        byte_err <= 1'b1;
                        st       <= RX_IDLE;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(tcnt) < TIMEOUT_CLKS); // R2
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        byte_start |-> st == RX_IDLE); // R9
    AST_STOP_GUARD: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> $past(line_in)); // R4

endmodule

// File: rtl/pkt_sequencer.sv
module pkt_sequencer
    import pkt_rx_pkg::*;
#(
    parameter int MAX_LEN    = 64,
    parameter bit ACCEPT_ALL = 1'b0,
    parameter int BUF_AW     = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        own_addr,
    input  logic              attn_in,
    input  logic              byte_valid,
    input  logic              byte_err,
    input  logic [7:0]        byte_data,
    output logic              byte_start,
    output logic              wr_en,
    output logic [BUF_AW-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output pkt_status_e       status
);
    ctl_state_e        st;
    logic              attn_q;
    logic [7:0]        remain;
    logic [BUF_AW-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= C_IDLE;
            attn_q     <= 1'b1;
            remain     <= '0;
            ptr        <= '0;
            byte_start <= 1'b0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            done       <= 1'b0;
            status     <= PKT_OK;
        end else begin
            attn_q     <= attn_in;
            byte_start <= 1'b0;
            wr_en      <= 1'b0;
            done       <= 1'b0;
            if (st == C_IDLE) begin
                if (attn_q && !attn_in) begin
                    st         <= C_ADDR;
                    byte_start <= 1'b1;
                end
            end else if (byte_err) begin
                done   <= 1'b1;
                status <= PKT_IO_ERR;
                st     <= C_IDLE;
            end else if (byte_valid) begin
                case (st)
                    C_ADDR: begin
                        if (dest_accepted(own_addr, byte_data, ACCEPT_ALL)) begin
                            wr_en      <= 1'b1;
                            wr_addr    <= '0;
                            wr_data    <= byte_data;
                            st         <= C_LEN;
                            byte_start <= 1'b1;
                        end else begin
                            done   <= 1'b1;
                            status <= PKT_NOT_MINE;
                            st     <= C_IDLE;
                        end
                    end
                    C_LEN: begin
                        wr_en   <= 1'b1;
                        wr_addr <= BUF_AW'(1);
                        wr_data <= byte_data;
                        if (int'(byte_data) >= MAX_LEN) begin
                            done   <= 1'b1;
                            status <= PKT_CONTENT_ERR;
                            st     <= C_IDLE;
                        end else begin
                            remain     <= byte_data + 8'd1;
                            ptr        <= BUF_AW'(2);
                            st         <= C_BODY;
                            byte_start <= 1'b1;
                        end
                    end
                    default: begin
                        wr_en   <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= byte_data;
                        ptr     <= ptr + 1'b1;
                        remain  <= remain - 8'd1;
                        if (remain == 8'd1) begin
                            done   <= 1'b1;
                            status <= PKT_OK;
                            st     <= C_IDLE;
                        end else begin
                            byte_start <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> int'(wr_addr) <= MAX_LEN + 1); // R8
    AST_ADDR_FILTER: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == '0) |-> (ACCEPT_ALL || wr_data == own_addr || wr_data == BCAST_ADDR)); // R5
    AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (st == C_BODY) |-> int'(remain) <= MAX_LEN); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_NO_WR_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !wr_en); // R9

endmodule

// File: rtl/addr_pkt_receiver.sv
module addr_pkt_receiver
    import pkt_rx_pkg::*;
#(
    parameter int  CLK_PER_BIT  = 434,
    parameter int  TIMEOUT_CLKS = 50000,
    parameter int  MAX_LEN      = 64,
    parameter bit  ACCEPT_ALL   = 1'b0,
    localparam int BUF_AW       = $clog2(MAX_LEN + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        own_addr,
    input  logic              data_in,
    input  logic              attn_in,
    output logic              buf_wr_en,
    output logic [BUF_AW-1:0] buf_wr_addr,
    output logic [7:0]        buf_wr_data,
    output logic              pkt_done,
    output logic [1:0]        pkt_status
);
    logic        byte_start;
    logic        byte_valid;
    logic        byte_err;
    logic [7:0]  byte_data;
    pkt_status_e status;

    serial_byte_rx #(
        .CLK_PER_BIT (CLK_PER_BIT),
        .TIMEOUT_CLKS(TIMEOUT_CLKS)
    ) u_byte_rx (
        .clk       (clk),
        .rst       (rst),
        .byte_start(byte_start),
        .line_in   (data_in),
        .byte_valid(byte_valid),
        .byte_err  (byte_err),
        .byte_data (byte_data)
    );

    pkt_sequencer #(
        .MAX_LEN   (MAX_LEN),
        .ACCEPT_ALL(ACCEPT_ALL),
        .BUF_AW    (BUF_AW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .own_addr  (own_addr),
        .attn_in   (attn_in),
        .byte_valid(byte_valid),
        .byte_err  (byte_err),
        .byte_data (byte_data),
        .byte_start(byte_start),
        .wr_en     (buf_wr_en),
        .wr_addr   (buf_wr_addr),
        .wr_data   (buf_wr_data),
        .done      (pkt_done),
        .status    (status)
    );

    assign pkt_status = status;

endmodule

// File: tb/test_addr_pkt_receiver.sv
module test_addr_pkt_receiver;
    localparam int B    = 8;
    localparam int TO   = 40;
    localparam int MAXL = 6;
    localparam int AW   = 3;
    localparam logic [7:0] OWN = 8'h21;

    // {dest, len, seed, expected status for filtering instance}
    localparam logic [25:0] VEC [6] = '{
        {8'h21, 8'd3,   8'h10, 2'd0},
        {8'hFF, 8'd0,   8'h40, 2'd0},
        {8'h22, 8'd2,   8'h55, 2'd1},
        {8'h21, 8'd5,   8'hA0, 2'd0},
        {8'h21, 8'd6,   8'h07, 2'd3},
        {8'h21, 8'd200, 8'h33, 2'd3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic data_in = 1'b1;
    logic attn_in = 1'b1;

    logic          wa_en, wb_en, da, db;
    logic [AW-1:0] wa_addr, wb_addr;
    logic [7:0]    wa_data, wb_data;
    logic [1:0]    sa, sb;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [7:0] mem_a [8];
    logic [7:0] mem_b [8];
    int wcnt_a, wcnt_b, dcnt_a, dcnt_b, st_a, st_b;
    bit order_bad_a, order_bad_b;

    always #10 clk = ~clk;

    addr_pkt_receiver #(.CLK_PER_BIT(B), .TIMEOUT_CLKS(TO), .MAX_LEN(MAXL), .ACCEPT_ALL(1'b0))
    i_addr_pkt_receiver (
        .clk(clk), .rst(rst), .own_addr(OWN), .data_in(data_in), .attn_in(attn_in),
        .buf_wr_en(wa_en), .buf_wr_addr(wa_addr), .buf_wr_data(wa_data),
        .pkt_done(da), .pkt_status(sa)
    );

    addr_pkt_receiver #(.CLK_PER_BIT(B), .TIMEOUT_CLKS(TO), .MAX_LEN(MAXL), .ACCEPT_ALL(1'b1))
    i_addr_pkt_receiver_all (
        .clk(clk), .rst(rst), .own_addr(OWN), .data_in(data_in), .attn_in(attn_in),
        .buf_wr_en(wb_en), .buf_wr_addr(wb_addr), .buf_wr_data(wb_data),
        .pkt_done(db), .pkt_status(sb)
    );

    always @(negedge clk) begin
        if (wa_en) begin
            if (int'(wa_addr) != wcnt_a) order_bad_a = 1'b1;
            mem_a[wa_addr] = wa_data;
            wcnt_a++;
        end
        if (wb_en) begin
            if (int'(wb_addr) != wcnt_b) order_bad_b = 1'b1;
            mem_b[wb_addr] = wb_data;
            wcnt_b++;
        end
        if (da) begin dcnt_a++; st_a = int'(sa); end
        if (db) begin dcnt_b++; st_b = int'(sb); end
    end

    task automatic clear_mon();
        wcnt_a = 0; wcnt_b = 0; dcnt_a = 0; dcnt_b = 0;
        st_a = -1; st_b = -1; order_bad_a = 0; order_bad_b = 0;
        for (int i = 0; i < 8; i++) begin mem_a[i] = 8'h00; mem_b[i] = 8'h00; end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pay(input logic [7:0] seed, input int j);
        return seed + 8'(j * 29);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b);
        data_in = 1'b0;
        idle(B);
        for (int i = 0; i < 8; i++) begin
            data_in = b[i];
            idle(B);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b);
        data_in = 1'b1;
        idle(B);
    endtask

    task automatic send_frame(input logic [7:0] dest, input logic [7:0] len,
                              input logic [7:0] seed, input int nsend);
        send_byte(dest);
        send_byte(len);
        for (int j = 0; j < nsend; j++) send_byte(pay(seed, j));
    endtask

    task automatic check_pkt(input int inst, input logic [7:0] dest, input logic [7:0] len,
                             input logic [7:0] seed, input int exp_st);
        int exp_w;
        int dc, sc, wc;
        bit ob;
        exp_w = (exp_st == 0) ? int'(len) + 3 : (exp_st == 3) ? 2 : 0;
        dc = (inst == 0) ? dcnt_a : dcnt_b;
        sc = (inst == 0) ? st_a : st_b;
        wc = (inst == 0) ? wcnt_a : wcnt_b;
        ob = (inst == 0) ? order_bad_a : order_bad_b;
        chk(dc == 1, "R9 single done pulse", dc, 1);
        if (exp_st == 1)      chk(sc == exp_st, "R5 not-for-me status", sc, exp_st);
        else if (exp_st == 3) chk(sc == exp_st, "R7 content status", sc, exp_st);
        else if (inst == 1)   chk(sc == exp_st, "R6 accept-all status", sc, exp_st);
        else                  chk(sc == exp_st, "R8 received status", sc, exp_st);
        chk(wc == exp_w, "R8 write count", wc, exp_w);
        chk(!ob, "R8 write order", int'(ob), 0);
        if (exp_w > 0) begin
            int a0;
            a0 = (inst == 0) ? int'(mem_a[0]) : int'(mem_b[0]);
            chk(a0 == int'(dest), "R7 address at index 0", a0, int'(dest));
        end
        if (exp_w > 1) begin
            int l1;
            l1 = (inst == 0) ? int'(mem_a[1]) : int'(mem_b[1]);
            chk(l1 == int'(len), "R7 length at index 1", l1, int'(len));
        end
        if (exp_st == 0) begin
            for (int j = 0; j <= int'(len); j++) begin
                int v;
                v = (inst == 0) ? int'(mem_a[2 + j]) : int'(mem_b[2 + j]);
                chk(v == int'(pay(seed, j)), "R3 R8 payload byte", v, int'(pay(seed, j)));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clear_mon();
        idle(4);
        chk(da == 1'b0 && wa_en == 1'b0, "R10 reset outputs", int'({da, wa_en}), 0);
        rst = 1'b0;
        idle(4);
        chk(da == 1'b0 && wa_en == 1'b0, "R10 outputs after reset", int'({da, wa_en}), 0);

        // Table of packets
        for (int k = 0; k < 6; k++) begin
            logic [7:0] dest, len, seed;
            int est, nsend;
            dest = VEC[k][25:18];
            len  = VEC[k][17:10];
            seed = VEC[k][9:2];
            est  = int'(VEC[k][1:0]);
            nsend = (int'(len) < MAXL) ? int'(len) + 1 : 2;
            clear_mon();
            attn_in = 1'b0;
            idle(2 * B);
            send_frame(dest, len, seed, nsend);
            idle(4);
            attn_in = 1'b1;
            idle(30);
            check_pkt(0, dest, len, seed, est);
            check_pkt(1, dest, len, seed, (est == 1) ? 0 : est);
        end

        // R2: no start bit after attention
        clear_mon();
        attn_in = 1'b0;
        idle(TO + 20);
        attn_in = 1'b1;
        idle(10);
        chk(dcnt_a == 1 && st_a == 2, "R2 start timeout status", st_a, 2);
        chk(wcnt_a == 0, "R2 no writes", wcnt_a, 0);

        // R4: stop bit never arrives
        clear_mon();
        attn_in = 1'b0;
        idle(2 * B);
        send_bits(8'h21);
        data_in = 1'b0;
        idle(TO + 20);
        data_in = 1'b1;
        attn_in = 1'b1;
        idle(20);
        chk(dcnt_a == 1 && st_a == 2, "R4 stop timeout status", st_a, 2);
        chk(wcnt_a == 0, "R4 no writes", wcnt_a, 0);

        // R11: timeout mid-packet keeps earlier bytes
        clear_mon();
        attn_in = 1'b0;
        idle(2 * B);
        send_byte(8'h21);
        send_byte(8'd3);
        send_byte(8'h5A);
        idle(TO + 20);
        attn_in = 1'b1;
        idle(10);
        chk(dcnt_a == 1 && st_a == 2, "R11 mid-packet timeout status", st_a, 2);
        chk(wcnt_a == 3, "R11 bytes kept", wcnt_a, 3);
        chk(mem_a[2] == 8'h5A, "R11 stored byte", int'(mem_a[2]), 'h5A);

        // R1: frame without attention fall is ignored
        clear_mon();
        send_frame(8'h21, 8'd1, 8'h11, 2);
        idle(TO + 20);
        chk(dcnt_a == 0 && dcnt_b == 0, "R1 no done without attention", dcnt_a + dcnt_b, 0);
        chk(wcnt_a == 0 && wcnt_b == 0, "R1 no writes without attention", wcnt_a + wcnt_b, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule